// File: doc/BRIEF.md
# Predicated Vector Float-to-Unsigned Converter

This block takes one vector register of floating-point lanes and produces a vector of unsigned integers, truncating each value toward zero. A 4-bit selector chooses one of seven pairings of source format and result width. The source can be half, single or double precision. The result can be 16, 32 or 64 bits wide. Each lane is as wide as the larger of the two. When the source is the smaller type, it sits in the low bits of its lane. When the result is the smaller type, it is zero-extended to fill the lane.

The caller presents the source vector, the previous destination vector, a byte-granular predicate and the selector, and pulses `start`. The block then works through one lane per clock. Active lanes receive the converted value. Inactive lanes keep the bits of the previous destination. A one-cycle `done` pulse marks the end. The invalid and inexact flags are accumulated over the active lanes of that operation. A selector outside the seven legal codes raises `err` and leaves the destination untouched.

Top module: `fp2u_vec_conv`

## Requirements
- R1: The selector codes are: 0101 half→16, 0110 half→32, 0111 half→64, 1010 single→32, 1110 single→64, 1100 double→32, 1111 double→64. For any legal code, `err` is 0 after the operation.
- R2: The container size C is the larger of the source and result widths. The number of lanes is VLEN/C. Lane i occupies `dst_out[i*C +: C]`.
- R3: Lane i is active when predicate bit i*C/8 is 1. The other predicate bits of the lane have no effect. An inactive lane equals the same bits of `old_vec`.
- R4: A source narrower than C is read from the low bits of its lane, and the upper lane bits are ignored. A result narrower than C is zero-extended to C bits.
- R5: Conversion truncates toward zero. Subnormal inputs give 0. A negative value whose truncation is zero gives 0 without raising invalid.
- R6: These cases saturate and raise invalid:
  - NaN gives 0.
  - Negative infinity gives 0.
  - A negative value whose truncation is nonzero gives 0.
  - Positive infinity gives all ones of the result width.
  - A value at or above 2^width gives all ones of the result width.
- R7: Inexact is raised when an active, non-saturating lane discards a nonzero fraction. Both flags are ORed over active lanes only. Both are cleared when a start is accepted and hold their value until the next accepted start.
- R8: An illegal selector sets `err`, which holds until the next accepted start. In that case `dst_out` equals `old_vec`, both flags stay 0, and `done` still pulses.
- R9: One lane is written per clock. `done` is a single-cycle pulse, rising one cycle after the last lane is written. A `start` that arrives while an operation is in progress is ignored.
- R10: After reset, `dst_out`, `done`, `err` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| sel | input | 4 | Conversion selector |
| src_vec | input | VLEN | Floating-point source lanes |
| old_vec | input | VLEN | Previous destination contents, kept in inactive lanes |
| pred | input | VLEN/8 | One predicate bit per byte |
| dst_out | output | VLEN | Merged result vector |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Selector was illegal |
| flag_invalid | output | 1 | Some active lane saturated |
| flag_inexact | output | 1 | Some active lane lost a fraction |

## Verification
The assertions check the following on every cycle:
- The converted value never has bits set above the selected result width.
- Invalid and inexact are never raised together for one lane.
- An inactive lane leaves both flags unchanged.
- The lane index never passes the last lane.
- `done` never lasts two cycles.
- A `start` seen while running does not disturb the lane count.

Only the bench's sweeps can show that the converted values are numerically correct for every format pair. The same holds for the saturation thresholds at 2^width, for the merging of inactive lanes with the old destination, and for the behaviour of the illegal selector codes.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;

    typedef enum logic [1:0] {
        SRC_HALF,
        SRC_SINGLE,
        SRC_DOUBLE
    } src_fmt_e;

    typedef enum logic [1:0] {
        RES_W16,
        RES_W32,
        RES_W64
    } res_w_e;

    // Decoded operation: legality, formats and log2 of the lane size
    typedef struct packed {
        logic     legal;
        src_fmt_e sfmt;
        res_w_e   rw;
        logic [2:0] lane_sh;
    } cvt_cfg_t;

    typedef struct packed {
        logic [63:0] value;
        logic        invalid;
        logic        inexact;
    } cvt_out_t;

    localparam logic [3:0] SEL_H_16 = 4'b0101;
    localparam logic [3:0] SEL_H_32 = 4'b0110;
    localparam logic [3:0] SEL_H_64 = 4'b0111;
    localparam logic [3:0] SEL_S_32 = 4'b1010;
    localparam logic [3:0] SEL_S_64 = 4'b1110;
    localparam logic [3:0] SEL_D_32 = 4'b1100;
    localparam logic [3:0] SEL_D_64 = 4'b1111;

    function automatic cvt_cfg_t decode_sel(input logic [3:0] s);
        cvt_cfg_t c;
        c.legal   = 1'b1;
        c.sfmt    = SRC_HALF;
        c.rw      = RES_W16;
        c.lane_sh = 3'd4;
        case (s)
            SEL_H_16: begin c.sfmt = SRC_HALF;   c.rw = RES_W16; c.lane_sh = 3'd4; end
            SEL_H_32: begin c.sfmt = SRC_HALF;   c.rw = RES_W32; c.lane_sh = 3'd5; end
            SEL_H_64: begin c.sfmt = SRC_HALF;   c.rw = RES_W64; c.lane_sh = 3'd6; end
            SEL_S_32: begin c.sfmt = SRC_SINGLE; c.rw = RES_W32; c.lane_sh = 3'd5; end
            SEL_S_64: begin c.sfmt = SRC_SINGLE; c.rw = RES_W64; c.lane_sh = 3'd6; end
            SEL_D_32: begin c.sfmt = SRC_DOUBLE; c.rw = RES_W32; c.lane_sh = 3'd6; end
            SEL_D_64: begin c.sfmt = SRC_DOUBLE; c.rw = RES_W64; c.lane_sh = 3'd6; end
            default:  c.legal = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic [63:0] res_mask(input res_w_e rw);
        case (rw)
            RES_W16: return 64'h0000_0000_0000_FFFF;
            RES_W32: return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic int res_bits(input res_w_e rw);
        case (rw)
            RES_W16: return 16;
            RES_W32: return 32;
            default: return 64;
        endcase
    endfunction

    // Truncating conversion of the low source-width bits of raw
    function automatic cvt_out_t fp_to_uint(input logic [63:0] raw,
                                            input src_fmt_e sf,
                                            input res_w_e rw);
        cvt_out_t    r;
        logic        sgn;
        logic [10:0] efld;
        logic [10:0] eall;
        logic [51:0] frac;
        logic [52:0] mant;
        logic [63:0] ip;
        logic [63:0] sat;
        logic        fnz;
        logic        ovf;
        int          bias;
        int          e;
        int          ow;
        r    = '0;
        ip   = '0;
        fnz  = 1'b0;
        ovf  = 1'b0;
        sat  = res_mask(rw);
        ow   = res_bits(rw);
        case (sf)
            SRC_HALF: begin
                sgn = raw[15]; efld = {6'd0, raw[14:10]}; eall = 11'd31;
                frac = {raw[9:0], 42'd0}; bias = 15;
            end
            SRC_SINGLE: begin
                sgn = raw[31]; efld = {3'd0, raw[30:23]}; eall = 11'd255;
                frac = {raw[22:0], 29'd0}; bias = 127;
            end
            default: begin
                sgn = raw[63]; efld = raw[62:52]; eall = 11'd2047;
                frac = raw[51:0]; bias = 1023;
            end
        endcase
        mant = {1'b1, frac};
        e    = int'(efld) - bias;
        if (efld == eall) begin
            r.invalid = 1'b1;
            r.value   = (frac == '0 && !sgn) ? sat : 64'd0;
        end else if (efld == '0) begin
            r.inexact = (frac != '0);
        end else begin
            if (e < 0) begin
                fnz = 1'b1;
            end else if (e >= ow) begin
                ovf = 1'b1;
            end else if (e <= 52) begin
                ip  = 64'(mant >> (52 - e));
                fnz = (mant & ((53'd1 << (52 - e)) - 53'd1)) != '0;
            end else begin
                ip  = {11'd0, mant} << (e - 52);
            end
            if (ovf) begin
                r.invalid = 1'b1;
                r.value   = sgn ? 64'd0 : sat;
            end else if (sgn && ip != '0) begin
                r.invalid = 1'b1;
            end else begin
                r.value   = sgn ? 64'd0 : ip;
                r.inexact = fnz;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fp2u_sel_decode.sv
module fp2u_sel_decode
    import fp2u_pkg::*;
(
    input  logic [3:0] sel,
    output cvt_cfg_t   cfg
);
    always_comb begin
        cfg = decode_sel(sel);
    end
endmodule

// File: rtl/fp2u_lane_unit.sv
module fp2u_lane_unit
    import fp2u_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int IDXW = $clog2(VLEN / 16),
    localparam int OFFW = $clog2(VLEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VLEN-1:0]  src_vec,
    input  logic [VLEN/8-1:0] pred,
    input  logic [IDXW-1:0]  idx,
    input  cvt_cfg_t         cfg,
    output logic [OFFW-1:0]  lane_off,
    output logic             active,
    output cvt_out_t         conv
);
    logic [VLEN-1:0] shifted;
    logic [63:0]     raw;

    always_comb begin
        lane_off = OFFW'(idx) << cfg.lane_sh;
        shifted  = src_vec >> lane_off;
        raw      = shifted[63:0];
        active   = pred[lane_off[OFFW-1:3]];
        conv     = fp_to_uint(raw, cfg.sfmt, cfg.rw);
    end

    AST_RESULT_FITS: assert property (@(posedge clk) disable iff (rst)
        (conv.value & ~res_mask(cfg.rw)) == 64'd0);            // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(conv.invalid && conv.inexact));                      // R6
endmodule

// File: rtl/fp2u_seq_ctrl.sv
module fp2u_seq_ctrl #(
    parameter int VLEN = 128,
    localparam int IDXW = $clog2(VLEN / 16)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            sel_legal,
    input  logic [2:0]      lane_sh,
    output logic            accept,
    output logic            run,
    output logic [IDXW-1:0] idx,
    output logic            done
);
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;
    st_e             state;
    logic [IDXW-1:0] last_idx;

    always_comb begin
        last_idx = IDXW'((VLEN >> lane_sh) - 1);
        accept   = start && (state == ST_IDLE);
        run      = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= (state == ST_FIN);
            case (state)
                ST_IDLE: if (start) begin
                    idx   <= '0;
                    state <= sel_legal ? ST_RUN : ST_FIN;
                end
                ST_RUN: begin
                    if (idx == last_idx) state <= ST_FIN;
                    else                 idx   <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                        // R9
    AST_LANE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> idx <= last_idx);                               // R2
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (run && start && idx != last_idx) |=> (run && idx == $past(idx) + 1'b1)); // R9
endmodule

// File: rtl/fp2u_vec_conv.sv
module fp2u_vec_conv
    import fp2u_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int PW   = VLEN / 8,
    localparam int IDXW = $clog2(VLEN / 16),
    localparam int OFFW = $clog2(VLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [3:0]      sel,
    input  logic [VLEN-1:0] src_vec,
    input  logic [VLEN-1:0] old_vec,
    input  logic [PW-1:0]   pred,
    output logic [VLEN-1:0] dst_out,
    output logic            done,
    output logic            err,
    output logic            flag_invalid,
    output logic            flag_inexact
);
    cvt_cfg_t        cfg_live;
    cvt_cfg_t        cfg_q;
    logic [VLEN-1:0] src_q;
    logic [PW-1:0]   pred_q;
    logic [VLEN-1:0] dst_q;
    logic            inv_q, inx_q, err_q;
    logic            accept, run;
    logic [IDXW-1:0] idx;
    logic [OFFW-1:0] lane_off;
    logic            lane_act;
    cvt_out_t        conv;

    fp2u_sel_decode u_dec (
        .sel (sel),
        .cfg (cfg_live)
    );

    fp2u_seq_ctrl #(.VLEN(VLEN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .sel_legal (cfg_live.legal),
        .lane_sh   (cfg_q.lane_sh),
        .accept    (accept),
        .run       (run),
        .idx       (idx),
        .done      (done)
    );

    fp2u_lane_unit #(.VLEN(VLEN)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .src_vec  (src_q),
        .pred     (pred_q),
        .idx      (idx),
        .cfg      (cfg_q),
        .lane_off (lane_off),
        .active   (lane_act),
        .conv     (conv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            src_q  <= '0;
            pred_q <= '0;
            dst_q  <= '0;
            inv_q  <= 1'b0;
            inx_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (accept) begin
            cfg_q  <= cfg_live;
            src_q  <= src_vec;
            pred_q <= pred;
            dst_q  <= old_vec;
            inv_q  <= 1'b0;
            inx_q  <= 1'b0;
            err_q  <= !cfg_live.legal;
        end else if (run && lane_act) begin
            case (cfg_q.lane_sh)
                3'd4:    dst_q[lane_off +: 16] <= conv.value[15:0];
                3'd5:    dst_q[lane_off +: 32] <= conv.value[31:0];
                default: dst_q[lane_off +: 64] <= conv.value;
            endcase
            inv_q <= inv_q | conv.invalid;
            inx_q <= inx_q | conv.inexact;
        end
    end

    assign dst_out      = dst_q;
    assign err          = err_q;
    assign flag_invalid = inv_q;
    assign flag_inexact = inx_q;

    AST_INACTIVE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !lane_act && !start) |=> ($stable(flag_invalid) && $stable(flag_inexact))); // R7
    AST_ERR_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        err |-> (!flag_invalid && !flag_inexact));              // R8
endmodule

// File: tb/fp2u_vec_conv_tb.sv
`timescale 1ns/1ps
module fp2u_vec_conv_tb;
    localparam int VLEN = 128;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [3:0]      sel = '0;
    logic [VLEN-1:0] src = '0;
    logic [VLEN-1:0] old = '0;
    logic [PW-1:0]   pred = '0;
    logic [VLEN-1:0] dst_out;
    logic            done, err, flag_invalid, flag_inexact;

    int n_chk = 0;
    int n_bad = 0;

    fp2u_vec_conv #(.VLEN(VLEN)) u_dut (
        .clk(clk), .rst(rst), .start(start), .sel(sel),
        .src_vec(src), .old_vec(old), .pred(pred),
        .dst_out(dst_out), .done(done), .err(err),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [VLEN-1:0] act,
                             input logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s vector actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sat_of(input int ow);
        return (ow == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ow) - 64'd1);
    endfunction

    function automatic void sel_info(input logic [3:0] s, output bit legal,
                                     output int sf, output int ow);
        legal = 1'b1; sf = 16; ow = 16;
        case (s)
            4'b0101: begin sf = 16; ow = 16; end
            4'b0110: begin sf = 16; ow = 32; end
            4'b0111: begin sf = 16; ow = 64; end
            4'b1010: begin sf = 32; ow = 32; end
            4'b1110: begin sf = 32; ow = 64; end
            4'b1100: begin sf = 64; ow = 32; end
            4'b1111: begin sf = 64; ow = 64; end
            default: legal = 1'b0;
        endcase
    endfunction

    function automatic int ew_of(input int sf);
        return (sf == 16) ? 5 : (sf == 32) ? 8 : 11;
    endfunction
    function automatic int fw_of(input int sf);
        return (sf == 16) ? 10 : (sf == 32) ? 23 : 52;
    endfunction

    // Arithmetic reference: value = mantissa * 2^exponent, then truncate
    function automatic void model(input logic [63:0] x, input int sf, input int ow,
                                  output logic [63:0] v, output bit inv, output bit inx);
        int ew, fw, bias;
        longint unsigned ef, fr;
        bit s;
        real mag, ip, hi, lo;
        ew = ew_of(sf); fw = fw_of(sf); bias = (1 << (ew - 1)) - 1;
        ef = (x >> fw) & ((64'd1 << ew) - 64'd1);
        fr = x & ((64'd1 << fw) - 64'd1);
        s  = x[sf-1];
        v = '0; inv = 1'b0; inx = 1'b0;
        if (ef == (64'd1 << ew) - 64'd1) begin
            inv = 1'b1;
            if (fr == 0 && !s) v = sat_of(ow);
            return;
        end
        if (ef == 0) mag = real'(fr) * $pow(2.0, real'(1 - bias - fw));
        else mag = (real'(fr) + $pow(2.0, real'(fw))) * $pow(2.0, real'(int'(ef) - bias - fw));
        ip = $floor(mag);
        if (s) begin
            if (ip != 0.0) inv = 1'b1;
            else inx = (mag != 0.0);
            return;
        end
        if (ip >= $pow(2.0, real'(ow))) begin
            inv = 1'b1; v = sat_of(ow);
            return;
        end
        hi = $floor(ip / 4294967296.0);
        lo = ip - hi * 4294967296.0;
        v = {32'(longint'(hi)), 32'(longint'(lo))};
        inx = (ip != mag);
    endfunction

    function automatic logic [63:0] gen_fp(input int sf, input int ow);
        int ew, fw, bias, emax, r, e, eb;
        logic [63:0] fr, ef;
        logic s;
        ew = ew_of(sf); fw = fw_of(sf); bias = (1 << (ew - 1)) - 1; emax = (1 << ew) - 1;
        fr = {$urandom, $urandom} & ((64'd1 << fw) - 64'd1);
        s  = ($urandom_range(0, 3) == 0);
        r  = int'($urandom_range(0, 11));
        case (r)
            0: begin ef = '0; fr = '0; end
            1: begin ef = 64'(emax); fr = '0; end
            2: begin ef = 64'(emax); fr = fr | 64'd1; end
            3: ef = '0;
            default: begin
                e  = int'($urandom_range(0, ow + 3)) - 2;
                eb = e + bias;
                if (eb < 1) eb = 1;
                if (eb > emax - 1) eb = emax - 1;
                ef = 64'(eb);
            end
        endcase
        return (64'(s) << (sf - 1)) | (ef << fw) | fr;
    endfunction

    task automatic expect_op(input logic [3:0] s, input logic [VLEN-1:0] sv,
                             input logic [VLEN-1:0] ov, input logic [PW-1:0] pv,
                             output logic [VLEN-1:0] ev, output bit ei, output bit ex);
        bit legal, li, lx;
        int sf, ow, c;
        logic [63:0] raw, val, cmask;
        sel_info(s, legal, sf, ow);
        ev = ov; ei = 1'b0; ex = 1'b0;
        if (!legal) return;
        c = (sf > ow) ? sf : ow;
        cmask = sat_of(c);
        for (int i = 0; i < VLEN / c; i++) begin
            if (pv[i * c / 8]) begin
                raw = 64'((sv >> (i * c)) & {{(VLEN-64){1'b0}}, cmask});
                model(raw, sf, ow, val, li, lx);
                ev = (ev & ~({{(VLEN-64){1'b0}}, cmask} << (i * c)))
                   | ({{(VLEN-64){1'b0}}, val} << (i * c));
                ei |= li; ex |= lx;
            end
        end
    endtask

    task automatic issue(input logic [3:0] s, input logic [VLEN-1:0] sv,
                         input logic [VLEN-1:0] ov, input logic [PW-1:0] pv);
        bit seen;
        @(negedge clk);
        sel = s; src = sv; old = ov; pred = pv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        if (!seen) begin
            n_chk++; n_bad++;
            $display("FAIL R9 done timeout actual=0 expected=1");
        end
    endtask

    task automatic run_checked(input logic [3:0] s, input logic [VLEN-1:0] sv,
                               input logic [VLEN-1:0] ov, input logic [PW-1:0] pv);
        logic [VLEN-1:0] ev;
        bit ei, ex, legal;
        int sf, ow, c;
        logic [63:0] cm;
        expect_op(s, sv, ov, pv, ev, ei, ex);
        issue(s, sv, ov, pv);
        sel_info(s, legal, sf, ow);
        if (!legal) begin
            check_vec("R8", dst_out, ov);
            check("R8", "err", 64'(err), 64'd1);
            check("R8", "flags", {62'd0, flag_invalid, flag_inexact}, 64'd0);
            return;
        end
        c = (sf > ow) ? sf : ow;
        cm = sat_of(c);
        for (int i = 0; i < VLEN / c; i++) begin
            if (!pv[i * c / 8])
                check("R3", "inactive lane", 64'(dst_out >> (i * c)) & cm, 64'(ev >> (i * c)) & cm);
            else if (sf != c || ow != c)
                check("R4", "mixed-size lane", 64'(dst_out >> (i * c)) & cm, 64'(ev >> (i * c)) & cm);
            else
                check("R2", "lane value", 64'(dst_out >> (i * c)) & cm, 64'(ev >> (i * c)) & cm);
        end
        check("R1", "err", 64'(err), 64'd0);
        check("R6", "invalid", 64'(flag_invalid), 64'(ei));
        check("R7", "inexact", 64'(flag_inexact), 64'(ex));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] codes [7];
        logic [VLEN-1:0] sv, ov, ev;
        logic [PW-1:0] pv;
        bit legal, ei, ex;
        int sf, ow, c, dn;
        codes = '{4'b0101, 4'b0110, 4'b0111, 4'b1010, 4'b1110, 4'b1100, 4'b1111};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check_vec("R10", dst_out, '0);
        check("R10", "done/err/flags", {60'd0, done, err, flag_invalid, flag_inexact}, 64'd0);

        // Sweeps over all legal conversions with random lanes
        for (int ci = 0; ci < 7; ci++) begin
            sel_info(codes[ci], legal, sf, ow);
            c = (sf > ow) ? sf : ow;
            for (int n = 0; n < 40; n++) begin
                sv = {$urandom, $urandom, $urandom, $urandom};
                ov = {$urandom, $urandom, $urandom, $urandom};
                pv = (n == 0) ? '1 : PW'($urandom);
                for (int i = 0; i < VLEN / c; i++) begin
                    sv = (sv & ~({{(VLEN-64){1'b0}}, sat_of(sf)} << (i * c)))
                       | ({{(VLEN-64){1'b0}}, gen_fp(sf, ow)} << (i * c));
                end
                run_checked(codes[ci], sv, ov, pv);
            end
        end

        // R8: every illegal selector code
        for (int s = 0; s < 16; s++) begin
            sel_info(4'(s), legal, sf, ow);
            if (!legal) run_checked(4'(s), {$urandom, $urandom, $urandom, $urandom},
                                    {$urandom, $urandom, $urandom, $urandom}, '1);
        end

        // R6 boundary: double->32, 2^32-0.5 and 2^32
        issue(4'b1100, {$realtobits(4294967296.0), $realtobits(4294967295.5)}, '0, '1);
        check("R6", "below 2^32", 64'(dst_out), 64'h0000_0000_FFFF_FFFF);
        check("R6", "at 2^32 saturates", 64'(dst_out >> 64), 64'h0000_0000_FFFF_FFFF);
        check("R6", "flags", {62'd0, flag_invalid, flag_inexact}, 64'd3);

        // R5: -0.5 truncates to zero without invalid; 3.75 -> 3
        issue(4'b1111, {$realtobits(3.75), $realtobits(-0.5)}, '1, '1);
        check("R5", "negative fraction", 64'(dst_out), 64'd0);
        check("R5", "truncation", 64'(dst_out >> 64), 64'd3);
        check("R5", "flags", {62'd0, flag_invalid, flag_inexact}, 64'd1);

        // R3: only non-leading predicate bits set -> nothing changes
        ov = {$urandom, $urandom, $urandom, $urandom};
        issue(4'b0101, {8{16'h4500}}, ov, {8{2'b10}});
        check_vec("R3", dst_out, ov);
        check("R7", "flags inactive", {62'd0, flag_invalid, flag_inexact}, 64'd0);

        // R9: start while running is ignored
        sv = {$realtobits(7.0), $realtobits(9.5)};
        ov = '0;
        expect_op(4'b1111, sv, ov, '1, ev, ei, ex);
        @(negedge clk);
        sel = 4'b1111; src = sv; old = ov; pred = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        sel = 4'b0101; src = '1; old = '1; pred = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dn = 0;
        for (int k = 0; k < 20 && dn == 0; k++) begin
            if (done) dn = 1;
            else @(negedge clk);
        end
        check_vec("R9", dst_out, ev);
        dn = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) dn++;
        end
        check("R9", "no extra done", 64'(dn), 64'd0);

        summary();
        $finish;
    end
endmodule